// File: doc/BRIEF.md
# Socket Status and Force Register Bank

This block holds the status registers of one card socket in a removable-card socket controller. It has four word registers on a simple 32-bit bus: an event register, an event mask, a present-state register and a write-only force register. The event register latches hardware event pulses until software clears them. The present-state register carries live copies of four socket status lines, plus card-type and fault flags.

The force register exists for test and diagnostics. A write to it can raise event bits, set card-type and fault flags, switch socket power control off, or ask external logic to interrogate the card again. Forcing an event never disturbs the live status copies. Interrogation is a request/done handshake. When done arrives, the block loads the card-type flags from sense inputs and turns power control back on.

An active-high interrupt is raised while any event bit whose mask bit is set is pending.

Top module: `sockstat_bank`

## Requirements
- R1: After reset the event bits, mask bits and all present-state flag bits (4 to 13) are 0, `pwr_ctl_en` is 1, and `irq` and `interrog_req` are 0.
- R2: A read of the force register (word offset 0Ch) returns 0. Write data bits 31..15 and bit 6 of a force write change no register.
- R3: A force write with data bits 3..0 set sets event bits 3..0 (3 power, 2 detect-2, 1 detect-1, 0 status-change), readable at offset 00h. The live bits 3..0 at offset 08h keep their values.
- R4: A write to offset 00h clears every event bit written as 1. A hardware set of the same bit in the same cycle wins and leaves the bit at 1.
- R5: A 1 on `hw_evt[i]` sets event bit i on the next clock edge.
- R6: A force write sets present-state bit n for each data bit n set among 4 (16-bit card), 5 (32-bit card), 7 (not a card), 8 (data lost) and 9 (bad supply request). Bus writes to offset 08h change nothing.
- R7: Force data bits 10 (5 V), 11 (3 V), 12 (X V) and 13 (Y V) set the same present-state bits. Any of them being set drives `pwr_ctl_en` to 0 on the next edge.
- R8: Force data bit 14 gives a one-cycle `interrog_req` on the edge of the write. A further bit-14 write before done arrives gives no request.
- R9: `interrog_done` during an interrogation loads present-state bits 4, 5, 10, 11, 12, 13 from `sense_card[0..5]`, clears bits 7, 8, 9 and sets `pwr_ctl_en`. A done pulse with no interrogation in progress is ignored.
- R10: Mask bits 3..0 are read/write at offset 04h. `irq` is 1 exactly while some event bit and its mask bit are both 1.
- R11: Present-state bits 3..0 show `live_sts` through one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte address; bits 3..2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_evt | input | 4 | Hardware event set pulses |
| live_sts | input | 4 | Live socket status lines |
| sense_card | input | 6 | Card-type sense result, valid with done |
| interrog_req | output | 1 | Interrogation request pulse |
| interrog_done | input | 1 | Interrogation complete |
| pwr_ctl_en | output | 1 | Socket power control enable |
| irq | output | 1 | Event interrupt |

## Verification
Every register result lands on the first clock edge after its stimulus. The bench drives each stimulus on a falling edge and reads the registers back on the next falling edge. `interrog_req` appears on the same edge as the force write, so it is checked right after the write and again one cycle later to prove it was a single pulse. `irq` and `bus_rdata` are combinational from registers, so they are read a short settle time after the address or the edge.

// File: rtl/sockstat_pkg.sv
package sockstat_pkg;
  localparam int EVT_N  = 4;
  localparam int PRES_W = 14;
  localparam int SENSE_W = 6;

  // present-state / force bit positions
  localparam int PB_16BIT  = 4;
  localparam int PB_CB     = 5;
  localparam int PB_RSVD   = 6;
  localparam int PB_NOCARD = 7;
  localparam int PB_DLOST  = 8;
  localparam int PB_BADV   = 9;
  localparam int PB_V5     = 10;
  localparam int PB_V3     = 11;
  localparam int PB_VX     = 12;
  localparam int PB_VY     = 13;
  localparam int FB_REPOLL = 14;

  typedef enum logic [1:0] {
    SEL_EVT   = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_PRES  = 2'd2,
    SEL_FORCE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sockstat_dec.sv
module sockstat_dec
  import sockstat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [EVT_N-1:0]  evt_q,
  input  logic [EVT_N-1:0]  mask_q,
  input  logic [PRES_W-1:0] pres_q,
  output logic              wr_evt,
  output logic              wr_mask,
  output logic              wr_force,
  output logic [DATA_W-1:0] rdata
);
  reg_sel_e sel;
  logic     unused_addr_lo;

  assign sel            = reg_sel_e'(bus_addr[3:2]);
  assign unused_addr_lo = ^{bus_addr[1:0], bus_addr[ADDR_W-1:2]};

  always_comb begin
    wr_evt   = 1'b0;
    wr_mask  = 1'b0;
    wr_force = 1'b0;
    if (bus_wr) begin
      case (sel)
        SEL_EVT:   wr_evt   = 1'b1;
        SEL_MASK:  wr_mask  = 1'b1;
        SEL_FORCE: wr_force = 1'b1;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_EVT:  rdata[EVT_N-1:0]  = evt_q;
      SEL_MASK: rdata[EVT_N-1:0]  = mask_q;
      SEL_PRES: rdata[PRES_W-1:0] = pres_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/sockstat_evt.sv
module sockstat_evt
  import sockstat_pkg::*;
#(
  parameter int N = EVT_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_evt,
  input  logic         wr_mask,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] force_set,
  output logic [N-1:0] evt_q,
  output logic [N-1:0] mask_q,
  output logic         irq
);
  logic [N-1:0] evt_d, clr;
  logic         evt_en;

  always_comb begin
    clr    = wr_evt ? wbits : '0;
    evt_d  = (evt_q & ~clr) | hw_set | force_set;
    evt_en = wr_evt | (|hw_set) | (|force_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else if (evt_en) begin
      evt_q <= evt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_mask) begin
      mask_q <= wbits;
    end
  end

  assign irq = |(evt_q & mask_q);
endmodule

// File: rtl/sockstat_pres.sv
module sockstat_pres
  import sockstat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EVT_N-1:0]   live_in,
  input  logic               force_wr,
  input  logic [FB_REPOLL:0] fdata,
  input  logic               done,
  input  logic [SENSE_W-1:0] sense,
  output logic [PRES_W-1:0]  pres_q,
  output logic               pwr_q,
  output logic               req_q,
  output logic               busy_q
);
  localparam logic [PRES_W-1:0] FORCE_MASK =
    PRES_W'((1 << PB_16BIT) | (1 << PB_CB) | (1 << PB_NOCARD) | (1 << PB_DLOST) |
            (1 << PB_BADV) | (1 << PB_V5) | (1 << PB_V3) | (1 << PB_VX) | (1 << PB_VY));

  logic [PRES_W-1:0] pres_d;
  logic              pwr_d, busy_d, start, done_ok, volt_force;

  always_comb begin
    done_ok    = done & busy_q;
    start      = force_wr & fdata[FB_REPOLL] & ~busy_q;
    volt_force = force_wr & (|fdata[PB_VY:PB_V5]);

    pres_d = pres_q;
    pres_d[EVT_N-1:0] = live_in;
    if (done_ok) begin
      pres_d[PB_16BIT]  = sense[0];
      pres_d[PB_CB]     = sense[1];
      pres_d[PB_V5]     = sense[2];
      pres_d[PB_V3]     = sense[3];
      pres_d[PB_VX]     = sense[4];
      pres_d[PB_VY]     = sense[5];
      pres_d[PB_NOCARD] = 1'b0;
      pres_d[PB_DLOST]  = 1'b0;
      pres_d[PB_BADV]   = 1'b0;
    end
    if (force_wr) begin
      pres_d = pres_d | (fdata[PRES_W-1:0] & FORCE_MASK);
    end
    pres_d[PB_RSVD] = 1'b0;

    pwr_d = pwr_q;
    if (done_ok)    pwr_d = 1'b1;
    if (volt_force) pwr_d = 1'b0;

    busy_d = busy_q;
    if (done_ok) busy_d = 1'b0;
    if (start)   busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= '0;
      pwr_q  <= 1'b1;
      busy_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      pres_q <= pres_d;
      pwr_q  <= pwr_d;
      busy_q <= busy_d;
      req_q  <= start;
    end
  end
endmodule

// File: rtl/sockstat_bank.sv
module sockstat_bank
  import sockstat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [EVT_N-1:0]   hw_evt,
  input  logic [EVT_N-1:0]   live_sts,
  input  logic [SENSE_W-1:0] sense_card,
  output logic               interrog_req,
  input  logic               interrog_done,
  output logic               pwr_ctl_en,
  output logic               irq
);
  logic              wr_evt, wr_mask, wr_force;
  logic [EVT_N-1:0]  evt_q, mask_q, force_evt;
  logic [PRES_W-1:0] pres_q;
  logic              busy;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:FB_REPOLL+1];
  assign force_evt       = wr_force ? bus_wdata[EVT_N-1:0] : '0;

  sockstat_dec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .evt_q    (evt_q),
    .mask_q   (mask_q),
    .pres_q   (pres_q),
    .wr_evt   (wr_evt),
    .wr_mask  (wr_mask),
    .wr_force (wr_force),
    .rdata    (bus_rdata)
  );

  sockstat_evt #(.N(EVT_N)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_evt    (wr_evt),
    .wr_mask   (wr_mask),
    .wbits     (bus_wdata[EVT_N-1:0]),
    .hw_set    (hw_evt),
    .force_set (force_evt),
    .evt_q     (evt_q),
    .mask_q    (mask_q),
    .irq       (irq)
  );

  sockstat_pres u_pres (
    .clk      (clk),
    .rst_n    (rst_n),
    .live_in  (live_sts),
    .force_wr (wr_force),
    .fdata    (bus_wdata[FB_REPOLL:0]),
    .done     (interrog_done),
    .sense    (sense_card),
    .pres_q   (pres_q),
    .pwr_q    (pwr_ctl_en),
    .req_q    (interrog_req),
    .busy_q   (busy)
  );
endmodule

// File: rtl/sockstat_chk.sv
module sockstat_chk
  import sockstat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [EVT_N-1:0]   hw_evt,
  input logic [EVT_N-1:0]   live_sts,
  input logic               interrog_req,
  input logic               interrog_done,
  input logic               pwr_ctl_en,
  input logic               irq,
  input logic [EVT_N-1:0]   evt_q,
  input logic [PRES_W-1:0]  pres_q,
  input logic               busy
);
  logic force_wr;
  assign force_wr = bus_wr && (bus_addr[3:2] == 2'd3);

  assert_force_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[3:2] == 2'd3) |-> (bus_rdata == '0));

  assert_live_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    force_wr |=> (pres_q[EVT_N-1:0] == $past(live_sts)));

  assert_hw_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt != '0) |=> ((evt_q & $past(hw_evt)) == $past(hw_evt)));

  assert_volt_pwr_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_wr && (|bus_wdata[PB_VY:PB_V5])) |=> !pwr_ctl_en);

  assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    interrog_req |=> !interrog_req);

  assert_done_pwr_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (interrog_done && busy && !(force_wr && (|bus_wdata[PB_VY:PB_V5]))) |=> pwr_ctl_en);

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(hw_evt) != '0 || $past(bus_wr)));
endmodule

bind sockstat_bank sockstat_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .hw_evt        (hw_evt),
  .live_sts      (live_sts),
  .interrog_req  (interrog_req),
  .interrog_done (interrog_done),
  .pwr_ctl_en    (pwr_ctl_en),
  .irq           (irq),
  .evt_q         (evt_q),
  .pres_q        (pres_q),
  .busy          (busy)
);

// File: tb/tb_sockstat_bank.sv
`timescale 1ns/1ps
module tb_sockstat_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  hw_evt, live_sts;
  logic [5:0]  sense_card;
  logic        interrog_req, interrog_done, pwr_ctl_en, irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sockstat_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_evt(hw_evt),
    .live_sts(live_sts), .sense_card(sense_card), .interrog_req(interrog_req),
    .interrog_done(interrog_done), .pwr_ctl_en(pwr_ctl_en), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'h0, v); check("R1 evt", v, 0);
    rd(4'h4, v); check("R1 mask", v, 0);
    rd(4'h8, v); check("R1 flags", v & 32'h3FF0, 0);
    check("R1 pwr", {31'd0, pwr_ctl_en}, 1);
    check("R1 irq/req", {30'd0, irq, interrog_req}, 0);
  endtask

  task automatic t_live;
    logic [31:0] v;
    @(negedge clk); live_sts = 4'b1010;
    @(negedge clk); rd(4'h8, v);
    check("R11 live", v & 32'hF, 32'hA);
  endtask

  task automatic t_force_events;
    logic [31:0] v;
    wr(4'hC, 32'h0000_0005);
    rd(4'h0, v); check("R3 evt 0,2", v, 32'h5);
    wr(4'hC, 32'h0000_000A);
    rd(4'h0, v); check("R3 evt all", v, 32'hF);
    rd(4'h8, v); check("R3 live untouched", v & 32'hF, 32'hA);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'hF; hw_evt = 4'b0010;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; hw_evt = '0;
    rd(4'h0, v); check("R4 set wins", v, 32'h2);
    wr(4'h0, 32'h2);
    rd(4'h0, v); check("R4 cleared", v, 0);
  endtask

  task automatic t_hw;
    logic [31:0] v;
    @(negedge clk); hw_evt = 4'b1000;
    @(negedge clk); hw_evt = '0;
    rd(4'h0, v); check("R5 hw set", v, 32'h8);
    wr(4'h0, 32'h8);
  endtask

  task automatic t_force_rsvd;
    logic [31:0] v;
    rd(4'hC, v); check("R2 read zero", v, 0);
    wr(4'hC, 32'hFFFF_8040);
    rd(4'h8, v); check("R2 rsvd no flag", v & 32'h3FF0, 0);
    rd(4'h0, v); check("R2 rsvd no evt", v, 0);
    check("R2 no req/pwr", {30'd0, interrog_req, pwr_ctl_en}, 1);
  endtask

  task automatic t_flags;
    logic [31:0] v;
    wr(4'h8, 32'h0000_3FF0);
    rd(4'h8, v); check("R6 pres write ignored", v & 32'h3FF0, 0);
    wr(4'hC, 32'h0000_03B0);
    rd(4'h8, v); check("R6 flags", v & 32'h3FF0, 32'h3B0);
    check("R6 pwr kept", {31'd0, pwr_ctl_en}, 1);
  endtask

  task automatic t_volt;
    logic [31:0] v;
    wr(4'hC, 32'h0000_1400);
    rd(4'h8, v); check("R7 volt bits", v & 32'h3C00, 32'h1400);
    check("R7 pwr off", {31'd0, pwr_ctl_en}, 0);
  endtask

  task automatic t_interrog;
    logic [31:0] v;
    wr(4'hC, 32'h0000_4000);
    check("R8 req pulse", {31'd0, interrog_req}, 1);
    @(negedge clk);
    check("R8 req drop", {31'd0, interrog_req}, 0);
    wr(4'hC, 32'h0000_4000);
    check("R8 no req when busy", {31'd0, interrog_req}, 0);
    sense_card = 6'b010101;
    interrog_done = 1'b1;
    @(negedge clk);
    interrog_done = 1'b0;
    rd(4'h8, v);
    check("R9 load", v & 32'h3FF0, 32'h0000_1410);
    check("R9 pwr on", {31'd0, pwr_ctl_en}, 1);
    sense_card = 6'b111111;
    interrog_done = 1'b1;
    @(negedge clk);
    interrog_done = 1'b0;
    rd(4'h8, v);
    check("R9 idle done ignored", v & 32'h3FF0, 32'h0000_1410);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(4'h4, 32'h4);
    rd(4'h4, v); check("R10 mask rw", v, 32'h4);
    wr(4'hC, 32'h1);
    check("R10 masked off", {31'd0, irq}, 0);
    wr(4'hC, 32'h4);
    check("R10 irq on", {31'd0, irq}, 1);
    wr(4'h0, 32'h4);
    check("R10 irq off", {31'd0, irq}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    hw_evt = '0; live_sts = '0; sense_card = '0; interrog_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_live();
    t_force_events();
    t_w1c();
    t_hw();
    t_force_rsvd();
    t_flags();
    t_volt();
    t_interrog();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule